// File: doc/BRIEF.md
# Inclusive outer-cache coherence filter

This block sits beside the tag array of an outer (L2) cache that is the only level watching the shared bus. For every L2 line it keeps a line state, an in-L1 flag and, when the private L1 is write-back, an L1-newer flag. Bus snoops, L2 allocations that may displace a line, and L1 fill, write-hit and eviction notices all arrive on one command port. The block updates its per-line bookkeeping and, only when the L1 can actually hold the affected line, issues an invalidate or copy-back request to the L1.

Each snoop also gets a hit/dirty response. The "dirty" answer accounts for data that is newer in the L1 than in the L2. A running count records how many snoops were resolved with no L1 traffic at all. The L1 and the bus sit outside the block, and no line data passes through it.

The L2 is direct-mapped in this filter's view. It has at least as many sets as the L1, and both levels use the same line size. This makes inclusion hold by construction. The set index is the low bits of the line address and the tag is the rest.

Top module: `l2_incl_filter`

## Requirements
- R1: After reset, no request or response pulses are driven, the filtered count is 0, and every line is invalid, so a first snoop misses.
- R2: Command opcodes on `cmd_op`:
  - 0 = snoop read
  - 1 = snoop read-exclusive
  - 2 = L2 allocate
  - 3 = L1 fill
  - 4 = L1 write hit
  - 5 = L1 evict

  A snoop read that hits answers hit=1 one cycle after the command. Its dirty bit is set if the line was modified in the L2 or newer in the L1. The line becomes clean-shared.
- R3: A snoop read-exclusive that hits invalidates the L2 line. If the in-L1 flag is set, it issues an L1 request in the same cycle as the response. The request kind (`l1_req_kind`) is:
  - 1 = invalidate, when the L1-newer flag is clear
  - 3 = copy back and invalidate, when the L1-newer flag is set
- R4: A snoop read that hits a line whose L1-newer flag is set issues kind 2 (copy back, L1 keeps the line) with dirty=1, then clears the flag. A repeat snoop read answers dirty=0 with no L1 request.
- R5: A snoop read-exclusive on an L1-newer line issues kind 3 and answers dirty=1.
- R6: An L2 allocate behaves as follows:
  - If it displaces a valid line of another tag whose in-L1 flag is set, it issues kind 1, or kind 3 if that line is L1-newer, addressed to the displaced line.
  - If the displaced line is not in the L1, it issues no request.
  - The new line starts clean with both flags clear.
- R7: An L1 fill for a line the L2 does not hold is ignored. A fill of a held line sets its in-L1 flag.
- R8: An L1 write hit marks the line L1-newer only when its in-L1 flag is set, and is ignored otherwise.
- R9: An L1 evict clears both flags. A line that was L1-newer becomes modified in the L2, so a later read-exclusive snoop answers dirty=1 with no L1 request.
- R10: Every snoop that produces no L1 request (miss, in-L1 flag clear, or nothing to pull) adds exactly one to `filt_count`. A snoop that produces an L1 request does not.
- R11: Request and response outputs are single-cycle pulses. None appears in a cycle that does not follow a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command opcode (see R2) |
| cmd_addr | input | ADDR_W | Line address of the command |
| l1_req_valid | output | 1 | L1 request pulse |
| l1_req_kind | output | 2 | 1 invalidate, 2 copy back keep, 3 copy back and invalidate |
| l1_req_addr | output | ADDR_W | Line address the L1 request targets |
| snp_rsp_valid | output | 1 | Snoop response pulse |
| snp_rsp_hit | output | 1 | Snoop hit in the L2 |
| snp_rsp_dirty | output | 1 | Hierarchy holds data newer than memory |
| filt_count | output | CNT_W | Snoops finished with no L1 traffic (saturating) |

## Verification
Every result of this block is due exactly one clock after the edge that takes the command: the L1 request, the snoop response and the new value of the filtered count. The bench drives each command on a falling edge. It queues the expected request, response and count with a due-cycle stamp equal to the next cycle number. A monitor compares the outputs on the falling edge of that cycle. Every cycle with nothing due is checked for the absence of pulses. Effects that are meant to be ignored, such as a fill on a miss or a write hit without the in-L1 flag, are exposed by a later snoop whose request and dirty answer reveal the stored flags.

// File: rtl/incl_filt_pkg.sv
package incl_filt_pkg;

   typedef enum logic [2:0] {
      OP_SNP_RD   = 3'd0,
      OP_SNP_RDX  = 3'd1,
      OP_L2_ALLOC = 3'd2,
      OP_L1_FILL  = 3'd3,
      OP_L1_WRHIT = 3'd4,
      OP_L1_EVICT = 3'd5
   } cmd_op_e;

   typedef enum logic [1:0] {
      L1_NONE       = 2'd0,
      L1_INVAL      = 2'd1,
      L1_COPY_KEEP  = 2'd2,
      L1_COPY_INVAL = 2'd3
   } l1_kind_e;

   typedef enum logic [1:0] {
      LN_INV   = 2'd0,
      LN_CLEAN = 2'd1,
      LN_DIRTY = 2'd2
   } line_st_e;

endpackage

// File: rtl/incl_dir_bank.sv
module incl_dir_bank
   import incl_filt_pkg::*;
#(
   parameter int SETS  = 16,
   parameter int TAG_W = 12,
   parameter bit WB_L1 = 1'b1,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag,
   output line_st_e         rd_st,
   output logic             rd_incl,
   output logic             rd_stale,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  line_st_e         wr_st,
   input  logic             wr_incl,
   input  logic             wr_stale
);

   logic [TAG_W-1:0] tag_a   [SETS];
   line_st_e         st_a    [SETS];
   logic             incl_a  [SETS];
   logic             stale_a [SETS];

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic [TAG_W-1:0] tag_r;
      line_st_e         st_r;
      logic             incl_r;
      logic             stale_r;
      logic             sel;

      assign sel = wr_en && (wr_idx == IDX_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_r  <= '0;
            st_r   <= LN_INV;
            incl_r <= 1'b0;
         end else if (sel) begin
            tag_r  <= wr_tag;
            st_r   <= wr_st;
            incl_r <= wr_incl;
         end
      end

      if (WB_L1) begin : g_wb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   stale_r <= 1'b0;
            else if (sel) stale_r <= wr_stale;
         end
      end else begin : g_wt
         assign stale_r = 1'b0;
      end

      assign tag_a[s]   = tag_r;
      assign st_a[s]    = st_r;
      assign incl_a[s]  = incl_r;
      assign stale_a[s] = stale_r;

      AST_INCL_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
         incl_r |-> (st_r != LN_INV)) else $error("in-L1 flag on invalid line"); // R7
      AST_STALE_NEEDS_INCL: assert property (@(posedge clk) disable iff (!rst_n)
         stale_r |-> incl_r) else $error("L1-newer flag without in-L1 flag"); // R8
   end

   assign rd_tag   = tag_a[rd_idx];
   assign rd_st    = st_a[rd_idx];
   assign rd_incl  = incl_a[rd_idx];
   assign rd_stale = stale_a[rd_idx];

endmodule

// File: rtl/incl_filt_ctrl.sv
module incl_filt_ctrl
   import incl_filt_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int IDX_W  = 4,
   parameter bit WB_L1  = 1'b1,
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [TAG_W-1:0]  rd_tag,
   input  line_st_e          rd_st,
   input  logic              rd_incl,
   input  logic              rd_stale,
   output logic              wr_en,
   output logic [TAG_W-1:0]  wr_tag,
   output line_st_e          wr_st,
   output logic              wr_incl,
   output logic              wr_stale,
   output logic              req_v,
   output l1_kind_e          req_kind,
   output logic [ADDR_W-1:0] req_addr,
   output logic              rsp_v,
   output logic              rsp_hit,
   output logic              rsp_dirty,
   output logic              filt_inc
);

   logic [IDX_W-1:0] idx;
   logic [TAG_W-1:0] tag;
   logic             valid_line;
   logic             hit;
   l1_kind_e         drop_kind;

   assign idx        = cmd_addr[IDX_W-1:0];
   assign tag        = cmd_addr[ADDR_W-1:IDX_W];
   assign valid_line = (rd_st != LN_INV);
   assign hit        = valid_line && (rd_tag == tag);
   assign drop_kind  = rd_stale ? L1_COPY_INVAL : L1_INVAL;

   always_comb begin
      wr_en     = 1'b0;
      wr_tag    = rd_tag;
      wr_st     = rd_st;
      wr_incl   = rd_incl;
      wr_stale  = rd_stale;
      req_v     = 1'b0;
      req_kind  = L1_NONE;
      req_addr  = cmd_addr;
      rsp_v     = 1'b0;
      rsp_hit   = 1'b0;
      rsp_dirty = 1'b0;
      if (cmd_valid) begin
         case (cmd_op)
            OP_SNP_RD: begin
               rsp_v     = 1'b1;
               rsp_hit   = hit;
               rsp_dirty = hit && ((rd_st == LN_DIRTY) || rd_stale);
               if (hit) begin
                  wr_en    = 1'b1;
                  wr_st    = LN_CLEAN;
                  wr_stale = 1'b0;
                  if (rd_stale) begin
                     req_v    = 1'b1;
                     req_kind = L1_COPY_KEEP;
                  end
               end
            end
            OP_SNP_RDX: begin
               rsp_v     = 1'b1;
               rsp_hit   = hit;
               rsp_dirty = hit && ((rd_st == LN_DIRTY) || rd_stale);
               if (hit) begin
                  wr_en    = 1'b1;
                  wr_st    = LN_INV;
                  wr_incl  = 1'b0;
                  wr_stale = 1'b0;
                  if (rd_incl) begin
                     req_v    = 1'b1;
                     req_kind = drop_kind;
                  end
               end
            end
            OP_L2_ALLOC: begin
               if (!hit) begin
                  wr_en    = 1'b1;
                  wr_tag   = tag;
                  wr_st    = LN_CLEAN;
                  wr_incl  = 1'b0;
                  wr_stale = 1'b0;
                  if (valid_line && rd_incl) begin
                     req_v    = 1'b1;
                     req_kind = drop_kind;
                     req_addr = {rd_tag, idx};
                  end
               end
            end
            OP_L1_FILL: begin
               if (hit) begin
                  wr_en   = 1'b1;
                  wr_incl = 1'b1;
               end
            end
            OP_L1_WRHIT: begin
               if (hit && rd_incl) begin
                  wr_en = 1'b1;
                  if (WB_L1) wr_stale = 1'b1;
                  else       wr_st    = LN_DIRTY;
               end
            end
            OP_L1_EVICT: begin
               if (hit) begin
                  wr_en    = 1'b1;
                  wr_incl  = 1'b0;
                  wr_stale = 1'b0;
                  if (rd_stale) wr_st = LN_DIRTY;
               end
            end
            default: ;
         endcase
      end
   end

   assign filt_inc = rsp_v && !req_v;

endmodule

// File: rtl/incl_filt_cnt.sv
module incl_filt_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         count <= '0;
      else if (inc && (count != CNT_MAX)) count <= count + CNT_W'(1);
   end

   AST_FILT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (count == $past(count)) || (count == $past(count) + CNT_W'(1)))
      else $error("filtered count moved by more than one"); // R10

endmodule

// File: rtl/l2_incl_filter.sv
module l2_incl_filter
   import incl_filt_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int L2_SETS = 16,
   parameter int L1_SETS = 8,
   parameter int CNT_W   = 16,
   parameter bit WB_L1   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   output logic              l1_req_valid,
   output logic [1:0]        l1_req_kind,
   output logic [ADDR_W-1:0] l1_req_addr,
   output logic              snp_rsp_valid,
   output logic              snp_rsp_hit,
   output logic              snp_rsp_dirty,
   output logic [CNT_W-1:0]  filt_count
);

   localparam int IDX_W = $clog2(L2_SETS);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (L2_SETS < L1_SETS) begin : g_bad_sets
      $error("L2 must have at least as many sets as L1");
   end
   if ((1 << IDX_W) != L2_SETS) begin : g_bad_pow2
      $error("L2_SETS must be a power of two");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W too small for the set index");
   end

   logic [TAG_W-1:0]  rd_tag, wr_tag;
   line_st_e          rd_st, wr_st;
   logic              rd_incl, rd_stale, wr_en, wr_incl, wr_stale;
   logic              req_v, rsp_v, rsp_hit, rsp_dirty, filt_inc;
   l1_kind_e          req_kind;
   logic [ADDR_W-1:0] req_addr;

   incl_dir_bank #(.SETS(L2_SETS), .TAG_W(TAG_W), .WB_L1(WB_L1)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (cmd_addr[IDX_W-1:0]),
      .rd_tag   (rd_tag),
      .rd_st    (rd_st),
      .rd_incl  (rd_incl),
      .rd_stale (rd_stale),
      .wr_en    (wr_en),
      .wr_idx   (cmd_addr[IDX_W-1:0]),
      .wr_tag   (wr_tag),
      .wr_st    (wr_st),
      .wr_incl  (wr_incl),
      .wr_stale (wr_stale)
   );

   incl_filt_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WB_L1(WB_L1)) u_ctrl (
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_addr  (cmd_addr),
      .rd_tag    (rd_tag),
      .rd_st     (rd_st),
      .rd_incl   (rd_incl),
      .rd_stale  (rd_stale),
      .wr_en     (wr_en),
      .wr_tag    (wr_tag),
      .wr_st     (wr_st),
      .wr_incl   (wr_incl),
      .wr_stale  (wr_stale),
      .req_v     (req_v),
      .req_kind  (req_kind),
      .req_addr  (req_addr),
      .rsp_v     (rsp_v),
      .rsp_hit   (rsp_hit),
      .rsp_dirty (rsp_dirty),
      .filt_inc  (filt_inc)
   );

   incl_filt_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (filt_inc),
      .count (filt_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l1_req_valid  <= 1'b0;
         l1_req_kind   <= L1_NONE;
         l1_req_addr   <= '0;
         snp_rsp_valid <= 1'b0;
         snp_rsp_hit   <= 1'b0;
         snp_rsp_dirty <= 1'b0;
      end else begin
         l1_req_valid  <= req_v;
         l1_req_kind   <= req_kind;
         l1_req_addr   <= req_addr;
         snp_rsp_valid <= rsp_v;
         snp_rsp_hit   <= rsp_hit;
         snp_rsp_dirty <= rsp_dirty;
      end
   end

   AST_REQ_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      l1_req_valid |-> (l1_req_kind != L1_NONE)) else $error("L1 request without kind"); // R3
   AST_MISS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_rsp_valid && !snp_rsp_hit) |-> !l1_req_valid) else $error("L1 request on snoop miss"); // R10
   AST_KEEP_IS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      (l1_req_valid && l1_req_kind == L1_COPY_KEEP) |-> (snp_rsp_valid && snp_rsp_dirty))
      else $error("copy-back without dirty read response"); // R4
   AST_PULSE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_rsp_valid || l1_req_valid) |-> $past(cmd_valid)) else $error("pulse without command"); // R11

endmodule

// File: tb/l2_incl_filter_bench.sv
module l2_incl_filter_bench;

   localparam int AW = 16;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = 3'd0;
   logic [AW-1:0] cmd_addr = '0;
   logic          l1_req_valid;
   logic [1:0]    l1_req_kind;
   logic [AW-1:0] l1_req_addr;
   logic          snp_rsp_valid, snp_rsp_hit, snp_rsp_dirty;
   logic [CW-1:0] filt_count;

   l2_incl_filter #(.ADDR_W(AW), .L2_SETS(16), .L1_SETS(8), .CNT_W(CW), .WB_L1(1'b1)) u_l2_incl_filter (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .l1_req_valid(l1_req_valid), .l1_req_kind(l1_req_kind), .l1_req_addr(l1_req_addr),
      .snp_rsp_valid(snp_rsp_valid), .snp_rsp_hit(snp_rsp_hit), .snp_rsp_dirty(snp_rsp_dirty),
      .filt_count(filt_count)
   );

   always #10 clk = ~clk;

   typedef struct {
      int            due;
      bit            rv;
      logic [1:0]    kind;
      logic [AW-1:0] raddr;
      bit            sv;
      bit            hit;
      bit            dirty;
      int            cnt;
      string         req;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   int   exp_cnt = 0;
   bit   running = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // driver: one command, then an idle cycle
   task automatic issue(logic [2:0] op, logic [AW-1:0] a, bit rv, logic [1:0] kind,
                        logic [AW-1:0] raddr, bit hit, bit dirty, string req);
      exp_t e;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
      e.due = cyc + 1; e.rv = rv; e.kind = kind; e.raddr = raddr;
      e.sv = (op <= 3'd1); e.hit = hit; e.dirty = dirty; e.req = req;
      if (e.sv && !rv) exp_cnt++;
      e.cnt = exp_cnt;
      q.push_back(e);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic act(logic [2:0] op, logic [AW-1:0] a, string req);
      issue(op, a, 1'b0, 2'd0, '0, 1'b0, 1'b0, req);
   endtask

   // monitor
   always @(negedge clk) begin
      if (running) begin
         if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            chk(l1_req_valid == e.rv, e.req, "l1_req_valid", l1_req_valid, e.rv);
            if (e.rv) begin
               chk(l1_req_kind == e.kind, e.req, "l1_req_kind", l1_req_kind, e.kind);
               chk(l1_req_addr == e.raddr, e.req, "l1_req_addr", l1_req_addr, e.raddr);
            end
            chk(snp_rsp_valid == e.sv, e.req, "snp_rsp_valid", snp_rsp_valid, e.sv);
            if (e.sv) begin
               chk(snp_rsp_hit == e.hit, e.req, "snp_rsp_hit", snp_rsp_hit, e.hit);
               chk(snp_rsp_dirty == e.dirty, e.req, "snp_rsp_dirty", snp_rsp_dirty, e.dirty);
            end
            chk(filt_count == CW'(e.cnt), e.req, "filt_count", filt_count, e.cnt);
         end else begin
            chk(!l1_req_valid && !snp_rsp_valid, "R11", "idle pulse",
                {l1_req_valid, snp_rsp_valid}, 0);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!l1_req_valid && !snp_rsp_valid, "R1", "pulses in reset", {l1_req_valid, snp_rsp_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(filt_count == 0, "R1", "count after reset", filt_count, 0);
      running = 1'b1;
      // R1: empty directory, snoop misses
      issue(3'd0, 16'h0011, 0, 0, 0, 0, 0, "R1");
      // R7: fill on miss ignored, shown by later snoop with no request
      act(3'd3, 16'h0022, "R7");
      act(3'd2, 16'h0022, "R7");
      issue(3'd1, 16'h0022, 0, 0, 0, 1, 0, "R7");
      // R2 / R3: clean hit, then exclusive snoop with in-L1 line
      act(3'd2, 16'h0011, "R2");
      act(3'd3, 16'h0011, "R7");
      issue(3'd0, 16'h0011, 0, 0, 0, 1, 0, "R2");
      issue(3'd1, 16'h0011, 1, 2'd1, 16'h0011, 1, 0, "R3");
      issue(3'd0, 16'h0011, 0, 0, 0, 0, 0, "R3");
      // R4 / R5: L1-newer line
      act(3'd2, 16'h0033, "R4");
      act(3'd3, 16'h0033, "R4");
      act(3'd4, 16'h0033, "R4");
      issue(3'd0, 16'h0033, 1, 2'd2, 16'h0033, 1, 1, "R4");
      issue(3'd0, 16'h0033, 0, 0, 0, 1, 0, "R4");
      act(3'd4, 16'h0033, "R5");
      issue(3'd1, 16'h0033, 1, 2'd3, 16'h0033, 1, 1, "R5");
      // R8: write hit without in-L1 flag ignored
      act(3'd2, 16'h0044, "R8");
      act(3'd4, 16'h0044, "R8");
      issue(3'd0, 16'h0044, 0, 0, 0, 1, 0, "R8");
      // R9: eviction of L1-newer line
      act(3'd2, 16'h0055, "R9");
      act(3'd3, 16'h0055, "R9");
      act(3'd4, 16'h0055, "R9");
      act(3'd5, 16'h0055, "R9");
      issue(3'd1, 16'h0055, 0, 0, 0, 1, 1, "R9");
      // R6: displacement
      act(3'd2, 16'h0066, "R6");
      act(3'd3, 16'h0066, "R6");
      issue(3'd2, 16'h0166, 1, 2'd1, 16'h0066, 0, 0, "R6");
      issue(3'd0, 16'h0066, 0, 0, 0, 0, 0, "R6");
      issue(3'd0, 16'h0166, 0, 0, 0, 1, 0, "R6");
      act(3'd3, 16'h0166, "R6");
      act(3'd4, 16'h0166, "R6");
      issue(3'd2, 16'h0266, 1, 2'd3, 16'h0166, 0, 0, "R6");
      issue(3'd2, 16'h0366, 0, 0, 0, 0, 0, "R6");
      issue(3'd0, 16'h0266, 0, 0, 0, 0, 0, "R10");
      issue(3'd0, 16'h0366, 0, 0, 0, 1, 0, "R10");
      repeat (3) @(negedge clk);
      running = 1'b0;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule